// File: doc/BRIEF.md
# Byte-Mapped Four-Input Stream Multiplexer

This block merges up to four incoming audio streams into a single outgoing stream. Each input delivers frames of up to sixteen 32-bit channel words over a valid/ready handshake, with a marker on the last word of each frame. The block holds one complete frame per input. It then builds each output frame one byte at a time. Every output byte can be taken from any byte of any word of any input.

The byte selection comes from a 16-word mapping memory, and each word of it packs four 8-bit selectors. Software loads and reads this memory through a control word and a data port, with optional address load and auto-increment. A 64-bit enable mask forces unused output bytes to zero. A release policy decides when an output frame starts. In wait-on-all mode it waits until every enabled input holds a frame. In wait-on-any mode the frame timing follows one chosen master input alone.

Top module: `byte_stream_merger`

## Requirements
- R1: An input accepts words (`in_ready` high) while it holds no complete frame. A frame closes on the word marked `in_last` or on the sixteenth word. From the next cycle `in_ready` stays low until that frame has been used by an output frame.
- R2: Output byte b travels in output word b/4, in lane L = b%4, bits [8L+7:8L]. It takes its value from the selector held in bits [8L+7:8L] of map word b/4. Selector bits [7:6] name the input, bits [5:2] name the word of that input's frame, and bits [1:0] name the byte lane, with lane L at bits [8L+7:8L] of that word.
- R3: When bit b of `cfg_byte_en` is 0, output byte b is 0 whatever its selector says.
- R4: A selector that points at a word index equal to or beyond the length of the chosen input's held frame yields 0.
- R5: When `cfg_dep` is not 1 (wait-on-all), no output frame starts until every input whose `cfg_in_en` bit is set holds a complete frame. Bytes from disabled inputs are 0. All frames used are released once the output frame completes.
- R6: When `cfg_dep` is 1 (wait-on-any), an output frame starts as soon as the input named by `cfg_master` holds a complete frame. Any other enabled input that holds a complete frame at that moment contributes and is released with it. Inputs without one yield 0 and keep their state.
- R7: An output frame has `cfg_out_words`+1 words, and `out_last` marks the final word. While `out_ready` is low, `out_valid`, `out_data` and `out_last` hold steady.
- R8: A write to the map control port with bit 13 set loads the address from bits [3:0]. Bit 14 selects write mode (1) or read mode (0). Bit 12 makes each data access advance the address by one, wrapping from 15 to 0; with it clear the address stays put.
- R9: A map data write issued in read mode changes neither the memory nor the address.
- R10: A map read strobe places the addressed map word on `map_data_rdata` in the following cycle, where it stays until the next strobe.
- R11: After reset `out_valid` and `out_last` are 0, every `in_ready` is 1, the map memory holds zeros and `map_data_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 4 | Per-input word valid |
| in_ready | output | 4 | Per-input ready; low while a complete frame is held |
| in_data | input | 128 | Per-input 32-bit word; input i on bits [32i+31:32i] |
| in_last | input | 4 | Per-input end-of-frame marker |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 32 | Assembled output word |
| out_last | output | 1 | Final word of the output frame |
| cfg_in_en | input | 4 | Inputs taking part in assembly |
| cfg_dep | input | 2 | Release policy: 1 wait-on-any, other values wait-on-all |
| cfg_master | input | 2 | Input that paces release in wait-on-any mode |
| cfg_out_words | input | 4 | Output frame length minus one |
| cfg_byte_en | input | 64 | Per-output-byte enable |
| map_ctrl_we | input | 1 | Map control write strobe |
| map_ctrl_wdata | input | 16 | Map control word (bits 14, 13, 12, 3:0 used) |
| map_data_we | input | 1 | Map data write strobe |
| map_data_wdata | input | 32 | Map data to write |
| map_data_rd | input | 1 | Map data read strobe |
| map_data_rdata | output | 32 | Map data read result |

## Verification
The bench builds the block with its default parameters: four inputs, sixteen-word frames and a 16-word map. At that size a sweep can load a fresh 64-selector map every round, reaching every input, word and lane, and can vary every input's frame length, the mask and the output length. Each round's output is compared word by word with an arithmetic model of the selection. Separate runs cover both release policies, a partially enabled input set, and frame-length boundaries at the referenced word. The map port checks cover address wrap, the fixed-address mode and the write attempted in read mode.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    // control word bit positions of the map access port
    localparam int CTRL_WR_POS   = 14;
    localparam int CTRL_INIT_POS = 13;
    localparam int CTRL_SEQ_POS  = 12;

    typedef enum logic [1:0] {
        DEP_ALL = 2'd0,
        DEP_ANY = 2'd1
    } dep_mode_e;

    // one byte selector: source input, word within frame, lane within word
    typedef struct packed {
        logic [1:0] strm;
        logic [3:0] word;
        logic [1:0] lane;
    } map_ent_t;
endpackage

// File: rtl/bsm_map_ram.sv
module bsm_map_ram
    import bsm_pkg::*;
#(
    parameter int MAP_WORDS = 16,
    parameter int DW        = 32,
    parameter int CTRL_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctrl_we,
    input  logic [CTRL_W-1:0]       ctrl_wdata,
    input  logic                    data_we,
    input  logic [DW-1:0]           data_wdata,
    input  logic                    data_rd,
    output logic [DW-1:0]           data_rdata,
    output logic [MAP_WORDS*DW-1:0] map_flat
);
    localparam int AW = $clog2(MAP_WORDS);

    typedef struct packed {
        logic [MAP_WORDS-1:0][DW-1:0] mem;
        logic [AW-1:0]                addr;
        logic                         wr_mode;
        logic                         seq;
        logic [DW-1:0]                rdata;
    } st_t;

    st_t d, q;
    logic do_wr;
    logic unused_ctrl_bits;

    assign unused_ctrl_bits = ^{ctrl_wdata[CTRL_W-1:CTRL_WR_POS+1],
                                ctrl_wdata[CTRL_SEQ_POS-1:AW]};
    assign do_wr = data_we && q.wr_mode;

    always_comb begin
        d = q;
        if (do_wr) begin
            d.mem[q.addr] = data_wdata;
        end
        if (data_rd) begin
            d.rdata = q.mem[q.addr];
        end
        if ((do_wr || data_rd) && q.seq) begin
            if (q.addr == AW'(MAP_WORDS - 1)) begin
                d.addr = '0;
            end else begin
                d.addr = q.addr + 1'b1;
            end
        end
        if (ctrl_we) begin
            d.wr_mode = ctrl_wdata[CTRL_WR_POS];
            d.seq     = ctrl_wdata[CTRL_SEQ_POS];
            if (ctrl_wdata[CTRL_INIT_POS]) begin
                d.addr = ctrl_wdata[AW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data_rdata = q.rdata;
    assign map_flat   = q.mem;
endmodule

// File: rtl/bsm_in_buf.sv
module bsm_in_buf #(
    parameter int WORDS = 16,
    parameter int DW    = 32,
    parameter int CNT_W = $clog2(WORDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DW-1:0]       in_data,
    input  logic                in_last,
    input  logic                consume,
    output logic                in_ready,
    output logic                full,
    output logic [CNT_W-1:0]    len,
    output logic [WORDS*DW-1:0] words_flat
);
    localparam int PW = $clog2(WORDS);

    typedef struct packed {
        logic [WORDS-1:0][DW-1:0] mem;
        logic [PW-1:0]            wptr;
        logic                     full;
        logic [CNT_W-1:0]         len;
    } st_t;

    st_t d, q;
    logic accept;

    assign accept = in_valid && !q.full;

    always_comb begin
        d = q;
        if (accept) begin
            d.mem[q.wptr] = in_data;
            if (in_last || (q.wptr == PW'(WORDS - 1))) begin
                d.full = 1'b1;
                d.len  = CNT_W'(q.wptr) + CNT_W'(1);
                d.wptr = '0;
            end else begin
                d.wptr = q.wptr + 1'b1;
            end
        end
        if (consume) begin
            d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_ready   = !q.full;
    assign full       = q.full;
    assign len        = q.len;
    assign words_flat = q.mem;
endmodule

// File: rtl/bsm_byte_sel.sv
module bsm_byte_sel
    import bsm_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int WORDS = 16,
    parameter int DW    = 32,
    parameter int CNT_W = $clog2(WORDS + 1)
) (
    input  logic [N_IN*WORDS*DW-1:0] frames,
    input  logic [N_IN*CNT_W-1:0]    lens,
    input  logic [N_IN-1:0]          fresh,
    input  logic [DW-1:0]            map_word,
    input  logic [LANES-1:0]         lane_en,
    output logic [DW-1:0]            out_word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] pick;

        always_comb begin
            map_ent_t e;
            int       src;
            logic     hit;
            e   = map_ent_t'(map_word[g*LANE_W +: LANE_W]);
            hit = lane_en[g] && (int'(e.strm) < N_IN) && (int'(e.word) < WORDS);
            if (hit) begin
                hit = fresh[e.strm] &&
                      (int'(e.word) < int'(lens[int'(e.strm)*CNT_W +: CNT_W]));
            end
            src = ((int'(e.strm) * WORDS + int'(e.word)) * DW) + int'(e.lane) * LANE_W;
            if (!hit) begin
                src = 0;
            end
            pick = hit ? frames[src +: LANE_W] : '0;
        end

        assign out_word[g*LANE_W +: LANE_W] = pick;
    end
endmodule

// File: rtl/byte_stream_merger.sv
module byte_stream_merger
    import bsm_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int WORDS  = 16,
    parameter int DW     = 32,
    parameter int CTRL_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_IN-1:0]              in_valid,
    output logic [N_IN-1:0]              in_ready,
    input  logic [N_IN*DW-1:0]           in_data,
    input  logic [N_IN-1:0]              in_last,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [DW-1:0]                out_data,
    output logic                         out_last,
    input  logic [N_IN-1:0]              cfg_in_en,
    input  logic [1:0]                   cfg_dep,
    input  logic [$clog2(N_IN)-1:0]      cfg_master,
    input  logic [$clog2(WORDS)-1:0]     cfg_out_words,
    input  logic [WORDS*LANES-1:0]       cfg_byte_en,
    input  logic                         map_ctrl_we,
    input  logic [CTRL_W-1:0]            map_ctrl_wdata,
    input  logic                         map_data_we,
    input  logic [DW-1:0]                map_data_wdata,
    input  logic                         map_data_rd,
    output logic [DW-1:0]                map_data_rdata
);
    localparam int OW_W  = $clog2(WORDS);
    localparam int CNT_W = $clog2(WORDS + 1);

    typedef struct packed {
        logic            emit;
        logic [N_IN-1:0] fresh;
        logic [OW_W-1:0] optr;
    } st_t;

    st_t d, q;

    logic [N_IN-1:0]          full_v;
    logic [N_IN-1:0]          avail;
    logic [N_IN-1:0]          consume;
    logic [N_IN*CNT_W-1:0]    lens;
    logic [N_IN*WORDS*DW-1:0] frames;
    logic [WORDS*DW-1:0]      map_flat;
    logic                     go_all, go_any, go, at_end, emit_done;

    // ---------------- input frame holders ----------------
    for (genvar i = 0; i < N_IN; i++) begin : g_in
        bsm_in_buf #(
            .WORDS (WORDS),
            .DW    (DW),
            .CNT_W (CNT_W)
        ) u_buf (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (in_valid[i]),
            .in_data    (in_data[i*DW +: DW]),
            .in_last    (in_last[i]),
            .consume    (consume[i]),
            .in_ready   (in_ready[i]),
            .full       (full_v[i]),
            .len        (lens[i*CNT_W +: CNT_W]),
            .words_flat (frames[i*WORDS*DW +: WORDS*DW])
        );
    end

    // ---------------- selector memory ----------------
    bsm_map_ram #(
        .MAP_WORDS (WORDS),
        .DW        (DW),
        .CTRL_W    (CTRL_W)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (map_ctrl_we),
        .ctrl_wdata (map_ctrl_wdata),
        .data_we    (map_data_we),
        .data_wdata (map_data_wdata),
        .data_rd    (map_data_rd),
        .data_rdata (map_data_rdata),
        .map_flat   (map_flat)
    );

    // ---------------- release policy and output sequencing ----------------
    assign avail     = full_v & cfg_in_en;
    assign go_all    = (cfg_in_en != '0) && (avail == cfg_in_en);
    assign go_any    = avail[cfg_master];
    assign go        = (cfg_dep == DEP_ANY) ? go_any : go_all;
    assign at_end    = (q.optr == cfg_out_words);
    assign emit_done = q.emit && out_ready && at_end;
    assign consume   = {N_IN{emit_done}} & q.fresh;

    always_comb begin
        d = q;
        if (!q.emit) begin
            if (go) begin
                d.emit  = 1'b1;
                d.fresh = avail;
                d.optr  = '0;
            end
        end else if (out_ready) begin
            if (at_end) begin
                d.emit  = 1'b0;
                d.fresh = '0;
            end else begin
                d.optr = q.optr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // ---------------- byte assembly ----------------
    bsm_byte_sel #(
        .N_IN  (N_IN),
        .WORDS (WORDS),
        .DW    (DW),
        .CNT_W (CNT_W)
    ) u_sel (
        .frames   (frames),
        .lens     (lens),
        .fresh    (q.fresh),
        .map_word (map_flat[int'(q.optr)*DW +: DW]),
        .lane_en  (cfg_byte_en[int'(q.optr)*LANES +: LANES]),
        .out_word (out_data)
    );

    assign out_valid = q.emit;
    assign out_last  = q.emit && at_end;
endmodule

// File: rtl/bsm_checker.sv
module bsm_checker #(
    parameter int N_IN = 4,
    parameter int DW   = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_IN-1:0]         in_valid,
    input logic [N_IN-1:0]         in_ready,
    input logic [N_IN-1:0]         in_last,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [DW-1:0]           out_data,
    input logic                    out_last,
    input logic [N_IN-1:0]         cfg_in_en,
    input logic [1:0]              cfg_dep,
    input logic [$clog2(N_IN)-1:0] cfg_master
);
    // R7: a stalled output word stays put
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R7: the frame marker only accompanies a valid word
    a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R5: wait-on-all starts only when every enabled input is holding a frame
    a_r5_all_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) && (cfg_dep != 2'd1) |-> ((in_ready & cfg_in_en) == '0));

    // R6: wait-on-any starts only when the master input is holding a frame
    a_r6_master_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) && (cfg_dep == 2'd1) |-> !in_ready[cfg_master]);

    // R1: a closing word makes the input stop accepting
    for (genvar i = 0; i < N_IN; i++) begin : g_close
        a_r1_close_stalls: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid[i] && in_ready[i] && in_last[i] |=> !in_ready[i]);
    end
endmodule

bind byte_stream_merger bsm_checker #(.N_IN(N_IN), .DW(DW)) u_bsm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_last    (in_last),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .cfg_in_en  (cfg_in_en),
    .cfg_dep    (cfg_dep),
    .cfg_master (cfg_master)
);

// File: tb/byte_stream_merger_bench.sv
module byte_stream_merger_bench;
    localparam int N  = 4;
    localparam int W  = 16;
    localparam int DW = 32;
    localparam int NB = W * 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      in_valid = '0;
    logic [N-1:0]      in_ready;
    logic [N*DW-1:0]   in_data = '0;
    logic [N-1:0]      in_last = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [DW-1:0]     out_data;
    logic              out_last;
    logic [N-1:0]      cfg_in_en = '1;
    logic [1:0]        cfg_dep = 2'd0;
    logic [1:0]        cfg_master = 2'd0;
    logic [3:0]        cfg_out_words = 4'd15;
    logic [NB-1:0]     cfg_byte_en = '1;
    logic              map_ctrl_we = 1'b0;
    logic [15:0]       map_ctrl_wdata = '0;
    logic              map_data_we = 1'b0;
    logic [DW-1:0]     map_data_wdata = '0;
    logic              map_data_rd = 1'b0;
    logic [DW-1:0]     map_data_rdata;

    always #4 clk = ~clk;

    byte_stream_merger u_byte_stream_merger (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .cfg_in_en(cfg_in_en), .cfg_dep(cfg_dep), .cfg_master(cfg_master),
        .cfg_out_words(cfg_out_words), .cfg_byte_en(cfg_byte_en),
        .map_ctrl_we(map_ctrl_we), .map_ctrl_wdata(map_ctrl_wdata),
        .map_data_we(map_data_we), .map_data_wdata(map_data_wdata),
        .map_data_rd(map_data_rd), .map_data_rdata(map_data_rdata)
    );

    int checks = 0;
    int fails  = 0;

    logic [7:0]  map_m [NB];
    logic [31:0] sent  [N][W];
    int          slen  [N];
    logic [N-1:0] fresh_m;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] dgen(input int r, input int s, input int w);
        logic [31:0] t;
        t = 32'(r * 64 + s * 16 + w + 1);
        return t * 32'h9E3779B1;
    endfunction

    function automatic logic [7:0] mgen(input int r, input int b);
        return 8'((b * 37 + r * 59 + 3) & 255);
    endfunction

    function automatic logic [31:0] exp_word(input int w);
        logic [31:0] res;
        res = '0;
        for (int k = 0; k < 4; k++) begin
            int b, st, wd, ln;
            b  = w * 4 + k;
            st = int'(map_m[b][7:6]);
            wd = int'(map_m[b][5:2]);
            ln = int'(map_m[b][1:0]);
            if (cfg_byte_en[b] && fresh_m[st] && (wd < slen[st]))
                res[8*k +: 8] = sent[st][wd][8*ln +: 8];
        end
        return res;
    endfunction

    // all tasks enter and leave at a falling edge
    task automatic ctrl_wr(input logic [15:0] v);
        map_ctrl_we = 1'b1; map_ctrl_wdata = v;
        @(negedge clk);
        map_ctrl_we = 1'b0;
    endtask

    task automatic data_wr(input logic [31:0] v);
        map_data_we = 1'b1; map_data_wdata = v;
        @(negedge clk);
        map_data_we = 1'b0;
    endtask

    task automatic data_rd_chk(input logic [31:0] exp, input string req);
        map_data_rd = 1'b1;
        @(negedge clk);
        map_data_rd = 1'b0;
        chk(map_data_rdata == exp, req, map_data_rdata, exp);
    endtask

    function automatic logic [31:0] map_word_m(input int w);
        return {map_m[4*w+3], map_m[4*w+2], map_m[4*w+1], map_m[4*w]};
    endfunction

    task automatic program_map(input bit readback);
        ctrl_wr(16'h7000);                 // write mode, load address 0, auto-increment
        for (int w = 0; w < W; w++) data_wr(map_word_m(w));
        if (readback) begin
            ctrl_wr(16'h3000);             // read mode, load address 0, auto-increment
            for (int w = 0; w < W; w++) data_rd_chk(map_word_m(w), "R8_R10 readback");
        end
    endtask

    task automatic send_frame(input int s, input int len, input int r);
        for (int w = 0; w < len; w++) begin
            in_valid[s] = 1'b1;
            in_data[s*DW +: DW] = dgen(r, s, w);
            in_last[s] = (w == len - 1);
            while (!in_ready[s]) @(negedge clk);
            @(negedge clk);
            sent[s][w] = dgen(r, s, w);
        end
        in_valid[s] = 1'b0;
        in_last[s]  = 1'b0;
        slen[s]     = len;
    endtask

    task automatic collect(input int nwords, input int hold, input string req);
        logic [31:0] first;
        out_ready = (hold == 0);
        while (!out_valid) @(negedge clk);
        if (hold > 0) begin
            first = out_data;
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                chk(out_valid && (out_data == first), "R7 stall hold", out_data, first);
            end
            out_ready = 1'b1;
        end
        for (int w = 0; w < nwords; w++) begin
            logic [31:0] e;
            while (!out_valid) @(negedge clk);
            e = exp_word(w);
            chk(out_data == e, req, out_data, e);
            chk(out_last == (w == nwords - 1), "R7 last marker", 32'(out_last), 32'(w == nwords - 1));
            @(negedge clk);
        end
        chk(out_valid == 1'b0, "R7 frame length", 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < N; s++) slen[s] = 0;
        fresh_m = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(out_valid == 1'b0, "R11 out_valid", 32'(out_valid), 0);
        chk(out_last == 1'b0, "R11 out_last", 32'(out_last), 0);
        chk(in_ready == 4'hF, "R11 in_ready", 32'(in_ready), 32'hF);
        chk(map_data_rdata == 0, "R11 rdata", map_data_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        ctrl_wr(16'h2000);
        data_rd_chk(32'd0, "R11 map cleared");

        // main sweep, wait-on-all with every input
        for (int r = 0; r < 8; r++) begin
            int nw;
            for (int b = 0; b < NB; b++) map_m[b] = mgen(r, b);
            cfg_byte_en = (r == 0) ? '1 : (~(64'h1 << (r * 7)) ^ ((r % 2 == 1) ? 64'h00FF_0000_F0F0_000F : 64'h0));
            cfg_out_words = 4'((r * 5 + 15) % 16);
            nw = int'(cfg_out_words) + 1;
            cfg_dep = 2'd0; cfg_in_en = 4'hF;
            program_map(1'b1);
            for (int s = 0; s < 3; s++) send_frame(s, ((r * 3 + s * 5) % 16) + 1, r);
            repeat (3) @(negedge clk);
            chk(out_valid == 1'b0, "R5 waits for all", 32'(out_valid), 0);
            chk(in_ready[0] == 1'b0, "R1 held frame stalls", 32'(in_ready[0]), 0);
            send_frame(3, ((r * 3 + 15) % 16) + 1, r);
            fresh_m = 4'hF;
            collect(nw, (r == 2) ? 3 : 0, "R2_R3_R4 assembled word");
            chk(in_ready == 4'hF, "R5 frames released", 32'(in_ready), 32'hF);
        end

        // R3: every byte disabled
        cfg_byte_en = '0; cfg_out_words = 4'd15;
        for (int s = 0; s < N; s++) send_frame(s, 16, 20);
        fresh_m = 4'hF;
        collect(16, 0, "R3 masked bytes zero");
        cfg_byte_en = '1;

        // R4: word 8 referenced against lengths 3, 16, 9, 8
        for (int b = 0; b < NB; b++) map_m[b] = {2'(b % 4), 4'd8, 2'(b % 4)};
        program_map(1'b0);
        send_frame(0, 3, 21); send_frame(1, 16, 21);
        send_frame(2, 9, 21); send_frame(3, 8, 21);
        fresh_m = 4'hF;
        collect(16, 0, "R4 beyond frame length");

        // R6: wait-on-any paced by input 2 alone
        for (int b = 0; b < NB; b++) map_m[b] = mgen(9, b);
        program_map(1'b0);
        cfg_dep = 2'd1; cfg_master = 2'd2;
        send_frame(2, 16, 30);
        fresh_m = 4'b0100;
        collect(16, 0, "R6 master only");
        chk(in_ready == 4'hF, "R6 master released", 32'(in_ready), 32'hF);
        send_frame(0, 5, 31);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R6 non-master does not release", 32'(out_valid), 0);
        send_frame(2, 11, 31);
        fresh_m = 4'b0101;
        collect(16, 0, "R6 master plus held input");
        chk(in_ready == 4'hF, "R6 both released", 32'(in_ready), 32'hF);

        // R5: wait-on-all with inputs 0 and 2 enabled
        cfg_dep = 2'd0; cfg_in_en = 4'b0101; cfg_out_words = 4'd7;
        send_frame(0, 16, 40);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R5 partial set waits", 32'(out_valid), 0);
        send_frame(2, 12, 40);
        fresh_m = 4'b0101;
        collect(8, 0, "R5 enabled subset");

        // R9: write in read mode is dropped
        ctrl_wr(16'h2003);
        data_wr(32'hDEAD_BEEF);
        data_rd_chk(map_word_m(3), "R9 read-mode write ignored");
        // R8: fixed address without auto-increment
        ctrl_wr(16'h2005);
        data_rd_chk(map_word_m(5), "R8 fixed address first");
        data_rd_chk(map_word_m(5), "R8 fixed address second");
        // R8: wrap from 15 to 0
        ctrl_wr(16'h700F);
        data_wr(32'hA1A2_A3A4);
        data_wr(32'hB1B2_B3B4);
        ctrl_wr(16'h300F);
        data_rd_chk(32'hA1A2_A3A4, "R8 wrap word 15");
        data_rd_chk(32'hB1B2_B3B4, "R8 wrap word 0");
        data_rd_chk(map_word_m(1), "R8_R10 next after wrap");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule